// File: doc/BRIEF.md
# Configuration File Section Locator

This block examines the opening bytes of a configuration file as they arrive one byte per accepted cycle. It first confirms that the stream opens with a fixed 13-byte signature. It then walks a chain of tagged sections until it meets the tag that was asked for, and reports that section's length. Each section is one ASCII tag byte, then a big-endian length, then that many content bytes. The tag `e` carries a four-byte length and every other tag carries a two-byte length. The content of sections that do not match is skipped.

A search begins with a one-cycle `start` pulse, which also captures the wanted tag. There are three ways a search can end. The signature can mismatch, which sets `bad_header`. The search can fail, which sets `not_found`. This happens on an unknown tag, on an implausible short length, or when the byte budget after the signature runs out. The wanted section can be located, which sets `found` and presents `sec_len`. After a match, the section's content bytes are handed downstream unchanged on the `pass_*` outputs, with the final one marked.

Top module: `cfgp_section_finder`

## Requirements
- R1: The first 13 accepted bytes after `start` must equal 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01 in that order. On the first byte that differs, `bad_header` rises on the next cycle and every later byte is ignored.
- R2: Tag 0x65 (`e`) is followed by a 4-byte length and any other tag by a 2-byte length. Both are most significant byte first.
- R3: A tag byte below 0x61 or above 0x65 ends the search with `not_found`.
- R4: A length above 255 attached to any tag other than 0x65 ends the search with `not_found`. A tag of 0x65 accepts any length.
- R5: When the tag equals the captured tag, `found` and `sec_len` become valid in the cycle after the final length byte is accepted. The length check of R4 takes priority over the match.
- R6: The content bytes of a section whose tag does not match are consumed without being forwarded, and the walk resumes at the next tag byte.
- R7: Tag, length and skipped content bytes together are counted against a budget of SEARCH_LIMIT (default 100). If the count has reached the limit when a tag or content byte would be needed next, the search ends with `not_found`. Length bytes are always read in full, and a match found in them still wins.
- R8: After a match, the next `sec_len` accepted bytes appear on `pass_byte` with `pass_valid` one cycle after acceptance. `pass_last` marks the final one. A zero length forwards nothing.
- R9: `start` captures `req_tag`, and later changes of `req_tag` have no effect. It also clears all result flags and restarts the parse. Bytes offered before the first `start` are ignored.
- R10: At most one of `found`, `not_found` and `bad_header` is high. Each holds its value until the next `start`.
- R11: A cycle with `in_valid` low consumes nothing and leaves the parse position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new search and capture `req_tag` |
| req_tag | input | 8 | Tag to look for |
| in_valid | input | 1 | `in_byte` carries a byte this cycle |
| in_byte | input | 8 | Stream byte |
| found | output | 1 | Requested section located |
| not_found | output | 1 | Search ended without a match |
| bad_header | output | 1 | Signature mismatch |
| sec_len | output | LEN_W (32) | Length of the located section |
| pass_valid | output | 1 | Forwarded content byte valid |
| pass_byte | output | 8 | Forwarded content byte |
| pass_last | output | 1 | Final forwarded content byte |

## Verification
The main function is tried with several files:
- a match in the first section, which tells apart an immediate match from walking on;
- a match in the second section, which shows the skip of the first section's content;
- files that pair a wide-length tag with a short-length tag in both orders, which tell the two length-field widths apart;
- tag bytes just outside the legal range on either side;
- a short length above 255 and a wide length of the same value, which separate the plausibility rule from the wide tag's exemption;
- a pair of files whose first section is one content byte apart in size, which places the budget edge exactly: one still matches and the other runs out.

Directed runs cover the remaining behaviours:
- a broken signature;
- bytes offered before any search;
- a restart after a failure;
- a stream with idle cycles between its bytes, which must give the same result as the dense stream.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int PRE_LEN = 13;

    localparam logic [7:0] TAG_FIRST = 8'h61;
    localparam logic [7:0] TAG_FINAL = 8'h65;
    localparam logic [7:0] TAG_WIDE  = 8'h65;
    localparam int         NARROW_MAX = 255;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_TAG,
        ST_LEN,
        ST_SKIP,
        ST_PASS,
        ST_END
    } state_e;

    // signature byte at a given position
    function automatic logic [7:0] pre_byte(input int idx);
        logic [7:0] v;
        case (idx)
            0:              v = 8'h00;
            1:              v = 8'h09;
            2, 4, 6, 8:     v = 8'h0F;
            3, 5, 7, 9:     v = 8'hF0;
            10, 11:         v = 8'h00;
            12:             v = 8'h01;
            default:        v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cfgp_preamble.sv
module cfgp_preamble
    import cfgp_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       byte_in,
    output logic             hit,
    output logic             final_pos
);

    always_comb begin
        hit       = (byte_in == pre_byte(int'(idx)));
        final_pos = (int'(idx) == PRE_LEN - 1);
    end

endmodule

// File: rtl/cfgp_budget.sv
module cfgp_budget #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic full_after
);

    localparam int CW = $clog2(LIMIT + 8);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc && (cnt_q != '1))
            cnt_d = cnt_q + 1'b1;
        // count after the byte now being consumed reaches the limit
        full_after = (cnt_q >= CW'(LIMIT - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7: the spent budget only grows between restarts
    a_r7_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cnt_q >= $past(cnt_q));

endmodule

// File: rtl/cfgp_fwd_stage.sv
module cfgp_fwd_stage (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       v_in,
    input  logic [7:0] b_in,
    input  logic       last_in,
    output logic       v_out,
    output logic [7:0] b_out,
    output logic       last_out
);

    logic       v_d, v_q, l_d, l_q;
    logic [7:0] b_d, b_q;

    always_comb begin
        v_d = clr ? 1'b0 : v_in;
        l_d = clr ? 1'b0 : (v_in && last_in);
        b_d = v_in ? b_in : b_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= 1'b0;
            l_q <= 1'b0;
            b_q <= '0;
        end else begin
            v_q <= v_d;
            l_q <= l_d;
            b_q <= b_d;
        end
    end

    assign v_out    = v_q;
    assign b_out    = b_q;
    assign last_out = l_q;

    // R8: the end marker only accompanies a forwarded byte
    a_r8_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_out |-> v_out);

endmodule

// File: rtl/cfgp_section_finder.sv
module cfgp_section_finder
    import cfgp_pkg::*;
#(
    parameter int LEN_W        = 32,
    parameter int SEARCH_LIMIT = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       req_tag,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             found,
    output logic             not_found,
    output logic             bad_header,
    output logic [LEN_W-1:0] sec_len,
    output logic             pass_valid,
    output logic [7:0]       pass_byte,
    output logic             pass_last
);

    localparam int IDX_W = $clog2(PRE_LEN);

    typedef struct packed {
        state_e           st;
        logic [7:0]       want;
        logic [7:0]       cur;
        logic [IDX_W-1:0] pidx;
        logic [1:0]       lcnt;
        logic [LEN_W-1:0] acc;
        logic [LEN_W-1:0] rem;
        logic [LEN_W-1:0] slen;
        logic             hit;
        logic             miss;
        logic             bad;
    } fsm_t;

    fsm_t q, d;

    logic             pre_hit, pre_final;
    logic             budget_full;
    logic             cnt_clr, cnt_inc;
    logic             fwd_v, fwd_last;
    logic [LEN_W-1:0] acc_n;

    cfgp_preamble #(.IDX_W(IDX_W)) u_pre (
        .idx       (q.pidx),
        .byte_in   (in_byte),
        .hit       (pre_hit),
        .final_pos (pre_final)
    );

    cfgp_budget #(.LIMIT(SEARCH_LIMIT)) u_budget (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (cnt_clr),
        .inc        (cnt_inc),
        .full_after (budget_full)
    );

    always_comb begin
        d        = q;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        fwd_v    = 1'b0;
        fwd_last = 1'b0;
        acc_n    = {q.acc[LEN_W-9:0], in_byte};

        if (start) begin
            d       = '0;
            d.st    = ST_PRE;
            d.want  = req_tag;
            cnt_clr = 1'b1;
        end else if (in_valid) begin
            unique case (q.st)
                ST_PRE: begin
                    if (!pre_hit) begin
                        d.bad = 1'b1;
                        d.st  = ST_END;
                    end else if (pre_final) begin
                        d.st = ST_TAG;
                    end else begin
                        d.pidx = q.pidx + 1'b1;
                    end
                end
                ST_TAG: begin
                    cnt_inc = 1'b1;
                    if ((in_byte < TAG_FIRST) || (in_byte > TAG_FINAL)) begin
                        d.miss = 1'b1;
                        d.st   = ST_END;
                    end else begin
                        d.cur  = in_byte;
                        d.lcnt = (in_byte == TAG_WIDE) ? 2'd3 : 2'd1;
                        d.acc  = '0;
                        d.st   = ST_LEN;
                    end
                end
                ST_LEN: begin
                    cnt_inc = 1'b1;
                    d.acc   = acc_n;
                    if (q.lcnt != 2'd0) begin
                        d.lcnt = q.lcnt - 1'b1;
                    end else if ((q.cur != TAG_WIDE) && (acc_n > LEN_W'(NARROW_MAX))) begin
                        d.miss = 1'b1;
                        d.st   = ST_END;
                    end else if (q.cur == q.want) begin
                        d.hit  = 1'b1;
                        d.slen = acc_n;
                        d.rem  = acc_n;
                        d.st   = (acc_n == '0) ? ST_END : ST_PASS;
                    end else if (budget_full) begin
                        d.miss = 1'b1;
                        d.st   = ST_END;
                    end else if (acc_n == '0) begin
                        d.st = ST_TAG;
                    end else begin
                        d.rem = acc_n;
                        d.st  = ST_SKIP;
                    end
                end
                ST_SKIP: begin
                    cnt_inc = 1'b1;
                    d.rem   = q.rem - 1'b1;
                    if (budget_full) begin
                        d.miss = 1'b1;
                        d.st   = ST_END;
                    end else if (q.rem == LEN_W'(1)) begin
                        d.st = ST_TAG;
                    end
                end
                ST_PASS: begin
                    fwd_v = 1'b1;
                    d.rem = q.rem - 1'b1;
                    if (q.rem == LEN_W'(1)) begin
                        fwd_last = 1'b1;
                        d.st     = ST_END;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    cfgp_fwd_stage u_fwd (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start),
        .v_in     (fwd_v),
        .b_in     (in_byte),
        .last_in  (fwd_last),
        .v_out    (pass_valid),
        .b_out    (pass_byte),
        .last_out (pass_last)
    );

    assign found      = q.hit;
    assign not_found  = q.miss;
    assign bad_header = q.bad;
    assign sec_len    = q.slen;

    // R10: outcomes are exclusive
    a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({found, not_found, bad_header}));

    // R10: outcomes persist until a restart
    a_r10_hit_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (found && !start) |=> found);
    a_r10_miss_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (not_found && !start) |=> not_found);
    a_r10_bad_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_header && !start) |=> bad_header);

    // R9: a restart clears every result
    a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !found && !not_found && !bad_header && !pass_valid);

    // R5: reported length stays put once found
    a_r5_len_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (found && !start) |=> $stable(sec_len));

    // R8: payload only flows after a match
    a_r8_pass_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        pass_valid |-> found);

    // R11: an idle cycle does not move the parse
    a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !start) |=> $stable(q.st) && $stable(q.rem) && $stable(q.pidx));

endmodule

// File: tb/sim_cfgp_section_finder.sv
module sim_cfgp_section_finder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  req_tag = 8'h00;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        found, not_found, bad_header;
    logic [31:0] sec_len;
    logic        pass_valid, pass_last;
    logic [7:0]  pass_byte;

    always #5 clk = ~clk;

    cfgp_section_finder u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .req_tag(req_tag),
        .in_valid(in_valid), .in_byte(in_byte),
        .found(found), .not_found(not_found), .bad_header(bad_header),
        .sec_len(sec_len), .pass_valid(pass_valid), .pass_byte(pass_byte),
        .pass_last(pass_last)
    );

    int n_run = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // forwarded payload capture
    logic [7:0] got [0:1023];
    int pcount = 0;
    int last_pos = -1;
    int last_cnt = 0;
    always @(negedge clk) begin
        if (pass_valid) begin
            if (pcount < 1024) got[pcount] = pass_byte;
            if (pass_last) begin
                last_pos = pcount;
                last_cnt++;
            end
            pcount++;
        end
    end

    // stream construction
    logic [7:0] strm [0:1023];
    int sn = 0;

    function automatic logic [7:0] content(input int k, input int i);
        return 8'((i * 7 + k * 64 + 3) & 255);
    endfunction

    task automatic put(input logic [7:0] b);
        strm[sn] = b;
        sn++;
    endtask

    task automatic put_pre();
        put(8'h00); put(8'h09);
        for (int i = 0; i < 4; i++) begin put(8'h0F); put(8'hF0); end
        put(8'h00); put(8'h00); put(8'h01);
    endtask

    task automatic put_sec(input logic [7:0] t, input logic [31:0] l, input int k);
        put(t);
        if (t == 8'h65) begin put(l[31:24]); put(l[23:16]); end
        put(l[15:8]); put(l[7:0]);
        for (int i = 0; i < int'(l); i++) put(content(k, i));
    endtask

    task automatic begin_search(input logic [7:0] t);
        pcount = 0; last_pos = -1; last_cnt = 0;
        @(negedge clk);
        start = 1'b1; req_tag = t;
        @(negedge clk);
        start = 1'b0; req_tag = 8'h7A;   // later changes must not matter
    endtask

    task automatic send_stream(input bit gaps);
        for (int i = 0; i < sn; i++) begin
            in_valid = 1'b1; in_byte = strm[i];
            @(negedge clk);
            if (gaps) begin
                in_valid = 1'b0; in_byte = 8'hEE;
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    typedef struct packed {
        logic [7:0]  req;
        logic [7:0]  t1;
        logic [31:0] l1;
        logic [7:0]  t2;
        logic [31:0] l2;
        logic        ef;
        logic        enf;
        logic [31:0] elen;
    } case_t;

    localparam int NC = 12;
    localparam case_t CASES [NC] = '{
        '{8'h61, 8'h61, 32'd3,   8'h00, 32'd0, 1'b1, 1'b0, 32'd3},   // R5 first section
        '{8'h63, 8'h61, 32'd4,   8'h63, 32'd2, 1'b1, 1'b0, 32'd2},   // R6 skip then match
        '{8'h65, 8'h62, 32'd5,   8'h65, 32'd6, 1'b1, 1'b0, 32'd6},   // R2 wide length match
        '{8'h61, 8'h65, 32'd2,   8'h61, 32'd1, 1'b1, 1'b0, 32'd1},   // R2 wide length skipped
        '{8'h64, 8'h61, 32'd2,   8'h62, 32'd1, 1'b0, 1'b1, 32'd0},   // R3 terminator byte
        '{8'h62, 8'h61, 32'd300, 8'h00, 32'd0, 1'b0, 1'b1, 32'd0},   // R4 short length too big
        '{8'h65, 8'h65, 32'd300, 8'h00, 32'd0, 1'b1, 1'b0, 32'd300}, // R4 wide exempt
        '{8'h62, 8'h62, 32'd0,   8'h00, 32'd0, 1'b1, 1'b0, 32'd0},   // R8 empty payload
        '{8'h63, 8'h61, 32'd96,  8'h63, 32'd1, 1'b1, 1'b0, 32'd1},   // R7 just inside budget
        '{8'h63, 8'h61, 32'd97,  8'h63, 32'd1, 1'b0, 1'b1, 32'd0},   // R7 budget spent
        '{8'h63, 8'h61, 32'd1,   8'h66, 32'd1, 1'b0, 1'b1, 32'd0},   // R3 above range
        '{8'h63, 8'h60, 32'd1,   8'h00, 32'd0, 1'b0, 1'b1, 32'd0}    // R3 below range
    };

    function automatic string case_req(input int c);
        case (c)
            0: return "R5";
            1: return "R6";
            2, 3: return "R2";
            4, 10, 11: return "R3";
            5, 6: return "R4";
            7: return "R8";
            default: return "R7";
        endcase
    endfunction

    task automatic build(input case_t cs);
        sn = 0;
        put_pre();
        put_sec(cs.t1, cs.l1, 0);
        if (cs.t2 != 8'h00) put_sec(cs.t2, cs.l2, 1);
        put(8'hFF);
    endtask

    task automatic run_case(input int c, input bit gaps, input string rq);
        case_t cs;
        int k;
        bit pay_ok;
        cs = CASES[c];
        build(cs);
        begin_search(cs.req);
        send_stream(gaps);
        chk(found == cs.ef, rq, found, cs.ef);
        chk(not_found == cs.enf, rq, not_found, cs.enf);
        chk(bad_header == 1'b0, "R1 no false signature error", bad_header, 0);
        if (cs.ef) begin
            k = (cs.t1 == cs.req) ? 0 : 1;
            chk(sec_len == cs.elen, rq, sec_len, cs.elen);
            chk(pcount == int'(cs.elen), "R8 payload count", pcount, cs.elen);
            pay_ok = 1'b1;
            for (int i = 0; i < pcount && i < 1024; i++)
                if (got[i] !== content(k, i)) pay_ok = 1'b0;
            chk(pay_ok, "R8 payload bytes", pay_ok, 1);
            if (cs.elen != 0) begin
                chk(last_cnt == 1 && last_pos == int'(cs.elen) - 1, "R8 last marker",
                    last_pos, int'(cs.elen) - 1);
            end
        end else begin
            chk(pcount == 0, "R6 nothing forwarded", pcount, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(!found && !not_found && !bad_header && !pass_valid, "R10 reset outcome",
            {found, not_found, bad_header, pass_valid}, 0);

        // R9: bytes before any start are ignored
        build(CASES[0]);
        send_stream(1'b0);
        chk(!found && !not_found && !bad_header, "R9 ignored before start",
            {found, not_found, bad_header}, 0);
        chk(pcount == 0, "R9 no payload before start", pcount, 0);

        // table walk
        for (int c = 0; c < NC; c++) run_case(c, 1'b0, case_req(c));

        // R1: broken signature at position 5
        build(CASES[0]);
        strm[5] = 8'h0E;
        begin_search(8'h61);
        send_stream(1'b0);
        chk(bad_header == 1'b1, "R1 signature mismatch", bad_header, 1);
        chk(!found && !not_found, "R1 parse halted", {found, not_found}, 0);
        chk(pcount == 0, "R1 no payload", pcount, 0);

        // R9: restart clears flags
        begin_search(8'h61);
        chk(!bad_header && !found && !not_found, "R9 restart clears",
            {found, not_found, bad_header}, 0);

        // R11: idle cycles between bytes give the same result
        run_case(1, 1'b1, "R11 gapped stream");
        run_case(8, 1'b1, "R11 gapped budget edge");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule